// File: doc/BRIEF.md
# Power-up reset timeout sequencer

This block keeps a device held in reset after a power-on event and lets it go only after a chain of timed stages has run. The first stage is a power-up delay measured in ticks of a slow internal RC clock. The second is an oscillator start-up count measured in main-oscillator cycles. The third is an optional PLL lock delay, also measured in RC ticks. Both timebases reach the block as single-cycle enables on one system clock.

Which stages run depends on what caused the sequence and on the oscillator configuration. A power-on pulse starts the full chain. The power-up stage is skipped when its enable bit is clear. The oscillator count runs only for the crystal and resonator mode codes. A wake-from-sleep pulse in the running state skips the power-up stage. It either re-runs the oscillator count (and the PLL delay, if enabled) or does nothing at all. A new power-on pulse at any time restarts the chain from its first stage.

The output is a reset hold line plus a stage code that software or a debugger can read.

Top module: `startup_hold`

## Requirements
- R1: After the synchronous reset `rst`, `stage` is IDLE (code 0) and `hold_rst` is 1; the block stays in IDLE until `pon_pulse` is seen.
- R2: `hold_rst` is 0 exactly when `stage` is RUN (code 4), and 1 in every other stage.
- R3: On a power-on pulse with `pwrt_en`=1, stage PWRT (code 1) is entered and lasts exactly `PWRT_TICKS` cycles with `rc_tick`=1; `osc_tick` does not advance it.
- R4: On a power-on pulse with `pwrt_en`=0, the PWRT stage is skipped entirely.
- R5: Stage OST (code 2) runs only for `osc_mode` codes 0 to 3 (bit 2 clear: LP, XT, HS, HS with PLL-capable crystal). It lasts exactly `OST_CYCLES` cycles with `osc_tick`=1. Codes 4 to 7 (external clock or RC) skip it.
- R6: When `pll_en`=1, stage PLL (code 3) follows the OST stage, or follows PWRT or the pulse when OST is skipped. It lasts exactly `PLL_TICKS` cycles with `rc_tick`=1. When `pll_en`=0, it is skipped.
- R7: A `pon_pulse` in any stage restarts the sequence from its first applicable stage, with fresh counts. `pon_pulse` takes priority over `wake_pulse` in the same cycle.
- R8: A `wake_pulse` in RUN goes straight to OST (then PLL per R6) for crystal modes, never through PWRT. For modes 4 to 7, it leaves the block in RUN with `hold_rst` at 0.
- R9: A `wake_pulse` outside RUN is ignored.
- R10: `stage` only ever holds codes 0 to 4, and it never returns to IDLE except through `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_tick | input | 1 | One-cycle enable per internal RC tick |
| osc_tick | input | 1 | One-cycle enable per main oscillator cycle |
| pon_pulse | input | 1 | Power-on event pulse |
| wake_pulse | input | 1 | Wake-from-sleep pulse |
| osc_mode | input | 3 | Oscillator mode code; bit 2 clear means crystal/resonator |
| pll_en | input | 1 | PLL enabled, appends the lock delay |
| pwrt_en | input | 1 | Power-up timer enable bit |
| hold_rst | output | 1 | Device reset hold, active high |
| stage | output | 3 | Stage code: 0 IDLE, 1 PWRT, 2 OST, 3 PLL, 4 RUN |

## Verification
A vector table sweeps every combination class of crystal versus non-crystal mode, PLL on or off, power-up timer on or off, and power-on versus wake cause. It counts the RC and oscillator ticks spent in each stage. A per-stage count of zero versus full length shows whether a stage was skipped or run. An off-by-one count shows a faulty counter limit. The RC and oscillator ticks are interleaved at different rates, so a stage counting the wrong timebase shows up as a wrong count. Directed cases cover a power-on restart in the middle of OST, wake pulses in IDLE and PWRT, and a simultaneous power-on and wake in RUN.

// File: rtl/startup_hold_pkg.sv
package startup_hold_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PWRT = 3'd1,
        ST_OST  = 3'd2,
        ST_PLL  = 3'd3,
        ST_RUN  = 3'd4
    } stage_e;

    localparam int MODE_W = 3;

    // Crystal and resonator modes are the codes with the top bit clear.
    function automatic logic mode_has_ost(input logic [MODE_W-1:0] mode);
        return (mode[MODE_W-1] == 1'b0);
    endfunction

    function automatic stage_e stage_after_ost(input logic pll);
        return pll ? ST_PLL : ST_RUN;
    endfunction

    function automatic stage_e stage_after_pwrt(input logic xtal, input logic pll);
        return xtal ? ST_OST : stage_after_ost(pll);
    endfunction

    function automatic stage_e stage_on_power(input logic pwrt, input logic xtal,
                                              input logic pll);
        return pwrt ? ST_PWRT : stage_after_pwrt(xtal, pll);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/startup_tick_counter.sv
module startup_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = en && (cnt_q == limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= done ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/startup_stage_fsm.sv
module startup_stage_fsm
    import startup_hold_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pon,
    input  logic   wake,
    input  logic   xtal,
    input  logic   pll_en,
    input  logic   pwrt_en,
    input  logic   rc_done,
    input  logic   osc_done,
    output stage_e cur,
    output logic   clr,
    output logic   hold
);
    stage_e nxt;

    always_comb begin
        nxt = cur;
        if (pon) begin
            nxt = stage_on_power(pwrt_en, xtal, pll_en);
        end else begin
            case (cur)
                ST_IDLE: nxt = ST_IDLE;
                ST_PWRT: if (rc_done)  nxt = stage_after_pwrt(xtal, pll_en);
                ST_OST:  if (osc_done) nxt = stage_after_ost(pll_en);
                ST_PLL:  if (rc_done)  nxt = ST_RUN;
                ST_RUN:  if (wake && xtal) nxt = ST_OST;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign clr = pon || (nxt != cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= ST_IDLE;
            hold <= 1'b1;
        end else begin
            cur  <= nxt;
            hold <= (nxt != ST_RUN);
        end
    end
endmodule

// File: rtl/startup_hold.sv
module startup_hold
    import startup_hold_pkg::*;
#(
    parameter int PWRT_TICKS = 1024,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rc_tick,
    input  logic              osc_tick,
    input  logic              pon_pulse,
    input  logic              wake_pulse,
    input  logic [MODE_W-1:0] osc_mode,
    input  logic              pll_en,
    input  logic              pwrt_en,
    output logic              hold_rst,
    output logic [2:0]        stage
);
    localparam int RC_W  = $clog2(max_of(PWRT_TICKS, PLL_TICKS) + 1);
    localparam int OSC_W = $clog2(OST_CYCLES + 1);

    stage_e          cur;
    logic            clr;
    logic            rc_done;
    logic            osc_done;
    logic            rc_en;
    logic            osc_en;
    logic            xtal;
    logic [RC_W-1:0] rc_limit;

    assign xtal     = mode_has_ost(osc_mode);
    assign rc_en    = rc_tick && ((cur == ST_PWRT) || (cur == ST_PLL));
    assign osc_en   = osc_tick && (cur == ST_OST);
    assign rc_limit = (cur == ST_PWRT) ? RC_W'(PWRT_TICKS) : RC_W'(PLL_TICKS);

    startup_tick_counter #(.W(RC_W)) u_rc_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .en    (rc_en),
        .limit (rc_limit),
        .done  (rc_done)
    );

    startup_tick_counter #(.W(OSC_W)) u_osc_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .en    (osc_en),
        .limit (OSC_W'(OST_CYCLES)),
        .done  (osc_done)
    );

    startup_stage_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pon      (pon_pulse),
        .wake     (wake_pulse),
        .xtal     (xtal),
        .pll_en   (pll_en),
        .pwrt_en  (pwrt_en),
        .rc_done  (rc_done),
        .osc_done (osc_done),
        .cur      (cur),
        .clr      (clr),
        .hold     (hold_rst)
    );

    assign stage = cur;
endmodule

// File: rtl/startup_hold_chk.sv
module startup_hold_chk (
    input logic       clk,
    input logic       rst,
    input logic       rc_tick,
    input logic       osc_tick,
    input logic       pon_pulse,
    input logic       wake_pulse,
    input logic [2:0] osc_mode,
    input logic       pll_en,
    input logic       pwrt_en,
    input logic       hold_rst,
    input logic [2:0] stage
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (stage == 3'd0 && hold_rst));

    assert_idle_wait_R1: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd0 && !pon_pulse) |=> stage == 3'd0);

    assert_hold_run_R2: assert property (@(posedge clk) disable iff (rst)
        hold_rst == (stage != 3'd4));

    assert_pwrt_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd1 && !rc_tick && !pon_pulse) |=> stage == 3'd1);

    assert_ost_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd2 && !osc_tick && !pon_pulse) |=> stage == 3'd2);

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (pon_pulse && (pwrt_en || !osc_mode[2] || pll_en)) |=> stage != 3'd4);

    assert_wake_noxtal_R8: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd4 && wake_pulse && !pon_pulse && osc_mode[2]) |=> stage == 3'd4);

    assert_stage_range_R10: assert property (@(posedge clk) disable iff (rst)
        stage <= 3'd4);

    assert_no_idle_return_R10: assert property (@(posedge clk) disable iff (rst)
        stage != 3'd0 |=> stage != 3'd0);
endmodule

bind startup_hold startup_hold_chk u_chk (.*);

// File: tb/startup_hold_bench.sv
module startup_hold_bench;
    localparam int P = 5;
    localparam int O = 8;
    localparam int L = 3;
    localparam int NV = 10;

    // {wake, pwrt_en, pll_en, mode[2:0], exp_pwrt[7:0], exp_ost[7:0], exp_pll[7:0]}
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 3'd0, 8'd5, 8'd8, 8'd0},
        {1'b0, 1'b1, 1'b1, 3'd1, 8'd5, 8'd8, 8'd3},
        {1'b0, 1'b1, 1'b0, 3'd4, 8'd5, 8'd0, 8'd0},
        {1'b0, 1'b0, 1'b1, 3'd5, 8'd0, 8'd0, 8'd3},
        {1'b0, 1'b0, 1'b0, 3'd2, 8'd0, 8'd8, 8'd0},
        {1'b0, 1'b0, 1'b1, 3'd3, 8'd0, 8'd8, 8'd3},
        {1'b0, 1'b0, 1'b0, 3'd7, 8'd0, 8'd0, 8'd0},
        {1'b1, 1'b1, 1'b0, 3'd2, 8'd0, 8'd8, 8'd0},
        {1'b1, 1'b1, 1'b1, 3'd3, 8'd0, 8'd8, 8'd3},
        {1'b1, 1'b1, 1'b1, 3'd6, 8'd0, 8'd0, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rc_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       pon_pulse = 1'b0;
    logic       wake_pulse = 1'b0;
    logic [2:0] osc_mode = 3'd0;
    logic       pll_en = 1'b0;
    logic       pwrt_en = 1'b1;
    logic       hold_rst;
    logic [2:0] stage;

    int  n_run = 0;
    int  n_fail = 0;
    int  cyc = 0;
    logic mon_clr = 1'b0;
    int  c_pw = 0, c_ost = 0, c_pll = 0;
    int  bad_stage = 0;
    logic seen_non_idle = 1'b0;

    startup_hold #(.PWRT_TICKS(P), .OST_CYCLES(O), .PLL_TICKS(L)) u_startup_hold (
        .clk(clk), .rst(rst), .rc_tick(rc_tick), .osc_tick(osc_tick),
        .pon_pulse(pon_pulse), .wake_pulse(wake_pulse), .osc_mode(osc_mode),
        .pll_en(pll_en), .pwrt_en(pwrt_en), .hold_rst(hold_rst), .stage(stage)
    );

    always #5 clk = ~clk;

    // Free-running tick enables at two different rates, changed off the active edge.
    always @(negedge clk) begin
        cyc      <= cyc + 1;
        rc_tick  <= (cyc % 3 == 0);
        osc_tick <= (cyc % 2 == 1);
    end

    // Counts ticks spent in each stage; also watches the code range (R10).
    always @(posedge clk) begin
        if (mon_clr) begin
            c_pw = 0; c_ost = 0; c_pll = 0;
        end else if (!rst) begin
            if (rc_tick && stage == 3'd1) c_pw++;
            if (osc_tick && stage == 3'd2) c_ost++;
            if (rc_tick && stage == 3'd3) c_pll++;
        end
        if (!rst) begin
            if (stage > 3'd4) bad_stage++;
            if (seen_non_idle && stage == 3'd0) bad_stage++;
            if (stage != 3'd0) seen_non_idle = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 100000)", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic p, input logic w);
        @(negedge clk);
        pon_pulse = p; wake_pulse = w; mon_clr = 1'b1;
        @(negedge clk);
        pon_pulse = 1'b0; wake_pulse = 1'b0; mon_clr = 1'b0;
    endtask

    task automatic wait_run(input string req);
        int k = 0;
        while (stage != 3'd4 && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check(req, int'(stage), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 stage after reset", int'(stage), 0);
        check("R1 hold after reset", int'(hold_rst), 1);
        repeat (10) @(negedge clk);
        check("R1 idle without power-on", int'(stage), 0);

        // R9: wake in IDLE ignored
        pulse(1'b0, 1'b1);
        check("R9 wake in idle", int'(stage), 0);

        // Table-driven sweep (R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < NV; i++) begin
            osc_mode = VEC[i][26:24];
            pll_en   = VEC[i][27];
            pwrt_en  = VEC[i][28];
            if (VEC[i][29]) begin
                pulse(1'b1, 1'b0);
                wait_run("R8 prep run");
                pulse(1'b0, 1'b1);
            end else begin
                pulse(1'b1, 1'b0);
            end
            wait_run("R2 reaches run");
            @(negedge clk);
            check("R3,R4 pwrt ticks", c_pw, int'(VEC[i][23:16]));
            check("R5 ost cycles", c_ost, int'(VEC[i][15:8]));
            check("R6 pll ticks", c_pll, int'(VEC[i][7:0]));
            check("R2 hold released in run", int'(hold_rst), 0);
        end

        // R7: power-on restart in the middle of OST
        osc_mode = 3'd0; pll_en = 1'b0; pwrt_en = 1'b1;
        pulse(1'b1, 1'b0);
        while (stage != 3'd2) @(negedge clk);
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b0);
        check("R7 restart enters pwrt", int'(stage), 1);
        check("R2 hold during pwrt", int'(hold_rst), 1);
        wait_run("R7 restart completes");
        @(negedge clk);
        check("R7 pwrt ticks after restart", c_pw, P);
        check("R7 ost cycles after restart", c_ost, O);

        // R9: wake during PWRT ignored
        pulse(1'b1, 1'b0);
        @(negedge clk);
        pulse(1'b0, 1'b1);
        check("R9 wake in pwrt", int'(stage), 1);
        wait_run("R9 run after ignored wake");

        // R7: power-on wins over wake in the same cycle
        pulse(1'b1, 1'b1);
        check("R7 pon over wake", int'(stage), 1);
        wait_run("R7 run after combined pulse");

        // R8: wake in RUN with a non-crystal mode stays released
        osc_mode = 3'd5; pll_en = 1'b1;
        pulse(1'b0, 1'b1);
        check("R8 wake non-crystal stage", int'(stage), 4);
        check("R8 wake non-crystal hold", int'(hold_rst), 0);

        check("R10 stage codes legal and no idle return", bad_stage, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule